// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block sits between core logic and a 64-bit wide data bus whose lines are active low. It limits how many lines are pulled low in any one transfer. On the transmit path, each 64-bit word is split into four 16-bit quarters. Any quarter that would hold more than half of its lines low is sent inverted, and an active-low flag for that quarter is raised alongside it. On the receive path, the bus word and its four flags come in, and every flagged quarter is flipped back before the word is handed on.

Each transfer phase is presented as a single-cycle valid pulse. Both paths register their outputs, so each has one clock of latency. A phase counter on the transmit side groups valid words into cache lines of eight phases. It marks the first and the last word of each line, and it gives a one-cycle pulse once a line has left the encoder.

Top module: `dbi_codec`

## Requirements
- R1: While reset is asserted and until the first valid input, `enc_valid`, `dec_valid`, `enc_first`, `enc_last` and `line_done` are 0. `enc_data` and `dec_data` are 0, and `enc_flag_n` is 4'b1111.
- R2: Quarter k of a word (bits 16k+15 down to 16k) is governed only by flag bit k. It is never affected by the other quarters.
- R3: A transmit quarter that holds 9 or more logical ones (lines low) is output bit-inverted, and its `enc_flag_n` bit is 0.
- R4: A transmit quarter that holds 8 or fewer ones, including exactly 8, is output unchanged, and its `enc_flag_n` bit is 1.
- R5: `enc_valid` equals `tx_valid` of the previous cycle. `enc_data`, `enc_flag_n`, `enc_first` and `enc_last` change only in the cycle after a valid transmit word, and otherwise hold.
- R6: `dec_valid` equals `rx_valid` of the previous cycle. For each quarter, `dec_data` holds the `rx_data` quarter inverted where `rx_flag_n` is 0, and unchanged where it is 1. It is updated only on valid input.
- R7: No quarter of a valid encoded word holds more than 8 ones. Feeding the encoder outputs back into the decoder returns the original word.
- R8: The phase count starts at 0 after reset and advances by one per valid transmit word, wrapping after 8. `enc_first` is 1 with the word sent at count 0, and `enc_last` is 1 with the word sent at count 7.
- R9: `line_done` is a one-cycle pulse in the cycle after the encoder presents a valid word with `enc_last` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit word valid (one phase) |
| tx_data | input | 64 | Transmit word, a 1 means line driven low |
| enc_valid | output | 1 | Encoded word valid |
| enc_data | output | 64 | Encoded bus word |
| enc_flag_n | output | 4 | Active-low inversion flags, bit k for quarter k |
| enc_first | output | 1 | Encoded word is phase 0 of a line |
| enc_last | output | 1 | Encoded word is phase 7 of a line |
| line_done | output | 1 | Pulse after the last word of a line |
| rx_valid | input | 1 | Received word valid |
| rx_data | input | 64 | Received bus word |
| rx_flag_n | input | 4 | Received active-low inversion flags |
| dec_valid | output | 1 | Decoded word valid |
| dec_data | output | 64 | Restored word |

## Verification
The only hidden state is the phase count. If it is wrong, `enc_first` and `enc_last` land on the wrong word within the same line, and `line_done` lands one cycle after that wrong word. Stalls between valid words are mixed in, so a counter that advances on idle cycles shows up as misplaced markers as well. The encoder and decoder registers are checked against a bench model every cycle, whether the input was valid or idle. This exposes a wrong hold value, or a decision at the 8-ones boundary, one cycle after the word that caused it.

// File: rtl/dbi_codec.sv
module dbi_codec #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int PHASES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              enc_valid,
  output logic [DATA_W-1:0] enc_data,
  output logic [DATA_W/SEG_W-1:0] enc_flag_n,
  output logic              enc_first,
  output logic              enc_last,
  output logic              line_done,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W/SEG_W-1:0] rx_flag_n,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data
);
  localparam int NSEG  = DATA_W / SEG_W;
  localparam int LIMIT = SEG_W / 2;
  localparam int OW    = $clog2(SEG_W + 1);
  localparam int CW    = (PHASES > 1) ? $clog2(PHASES) : 1;

  function automatic logic [OW-1:0] ones(input logic [SEG_W-1:0] v);
    logic [OW-1:0] n;
    n = '0;
    for (int i = 0; i < SEG_W; i++) n = n + OW'(v[i]);
    return n;
  endfunction

  logic [NSEG-1:0]   tx_inv;
  logic [DATA_W-1:0] tx_coded;
  logic [DATA_W-1:0] rx_plain;
  logic [CW-1:0]     phase;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign tx_inv[g] = ones(tx_data[g*SEG_W +: SEG_W]) > OW'(LIMIT);
    assign tx_coded[g*SEG_W +: SEG_W] = tx_data[g*SEG_W +: SEG_W] ^ {SEG_W{tx_inv[g]}};
    assign rx_plain[g*SEG_W +: SEG_W] = rx_data[g*SEG_W +: SEG_W] ^ {SEG_W{~rx_flag_n[g]}};

    assert_seg_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> ones(enc_data[g*SEG_W +: SEG_W]) <= OW'(LIMIT));
    assert_flag_inverted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_valid && !enc_flag_n[g]) |-> ones(enc_data[g*SEG_W +: SEG_W]) < OW'(SEG_W - LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_valid  <= 1'b0;
      enc_data   <= '0;
      enc_flag_n <= '1;
      enc_first  <= 1'b0;
      enc_last   <= 1'b0;
      line_done  <= 1'b0;
      phase      <= '0;
    end else begin
      enc_valid <= tx_valid;
      line_done <= enc_valid && enc_last;
      if (tx_valid) begin
        enc_data   <= tx_coded;
        enc_flag_n <= ~tx_inv;
        enc_first  <= (phase == '0);
        enc_last   <= (phase == CW'(PHASES - 1));
        phase      <= (phase == CW'(PHASES - 1)) ? '0 : phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_data  <= '0;
    end else begin
      dec_valid <= rx_valid;
      if (rx_valid) dec_data <= rx_plain;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> ($stable(enc_data) && $stable(enc_flag_n) && !enc_valid));
  assert_dec_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> dec_valid);
  assert_dec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(dec_data) && !dec_valid));
  assert_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |-> !(enc_first && enc_last));
  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> $past(enc_valid && enc_last));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
endmodule

// File: tb/sim_dbi_codec.sv
`timescale 1ns/1ps
module sim_dbi_codec;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, tx_valid, enc_valid, enc_first, enc_last, line_done;
  logic        rx_valid, dec_valid;
  logic [63:0] tx_data, enc_data, rx_data, dec_data;
  logic [3:0]  enc_flag_n, rx_flag_n;

  dbi_codec u0 (.clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .enc_valid(enc_valid), .enc_data(enc_data), .enc_flag_n(enc_flag_n),
    .enc_first(enc_first), .enc_last(enc_last), .line_done(line_done),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_flag_n(rx_flag_n),
    .dec_valid(dec_valid), .dec_data(dec_data));

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] x_flags(input logic [63:0] w);
    logic [3:0] f;
    for (int s = 0; s < 4; s++) f[s] = !($countones(w[s*16 +: 16]) > 8);
    return f;
  endfunction

  function automatic logic [63:0] x_enc(input logic [63:0] w);
    logic [3:0] f;
    logic [63:0] r;
    f = x_flags(w);
    for (int s = 0; s < 4; s++) r[s*16 +: 16] = f[s] ? w[s*16 +: 16] : ~w[s*16 +: 16];
    return r;
  endfunction

  function automatic logic [63:0] x_dec(input logic [63:0] d, input logic [3:0] f);
    logic [63:0] r;
    for (int s = 0; s < 4; s++) r[s*16 +: 16] = f[s] ? d[s*16 +: 16] : ~d[s*16 +: 16];
    return r;
  endfunction

  function automatic logic [15:0] rnd_seg();
    case ($urandom % 8)
      0: return 16'h00FF;
      1: return 16'h01FF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      4: return 16'hF0F0;
      5: return 16'h7F80;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [63:0] rnd_word();
    return {rnd_seg(), rnd_seg(), rnd_seg(), rnd_seg()};
  endfunction

  logic        e_valid = 0, e_first = 0, e_last = 0, e_done = 0, d_valid = 0;
  logic [63:0] e_data = 0, d_data = 0, orig = 0;
  logic [3:0]  e_flag = 4'hF;
  int          ph = 0;

  task automatic cycle(input logic tv, input logic [63:0] td, input logic loop,
                       input logic rv, input logic [63:0] rd, input logic [3:0] rf);
    logic nd, rt;
    logic [63:0] rt_word;
    @(negedge clk);
    rt = 0;
    rt_word = orig;
    if (loop) begin
      rx_valid = enc_valid; rx_data = enc_data; rx_flag_n = enc_flag_n;
      rt = enc_valid;
    end else begin
      rx_valid = rv; rx_data = rd; rx_flag_n = rf;
    end
    tx_valid = tv; tx_data = td;
    nd = e_valid && e_last;
    if (tv) begin
      e_data = x_enc(td); e_flag = x_flags(td);
      e_first = (ph == 0); e_last = (ph == 7);
      ph = (ph + 1) % 8;
      orig = td;
    end
    e_valid = tv; e_done = nd;
    d_valid = rx_valid;
    if (rx_valid) d_data = x_dec(rx_data, rx_flag_n);
    @(posedge clk); #1;
    chk("R5 enc_valid", enc_valid, e_valid);
    chk("R3 R4 enc_data", enc_data, e_data);
    chk("R2 enc_flag_n", enc_flag_n, e_flag);
    chk("R8 enc_first", enc_first, e_first);
    chk("R8 enc_last", enc_last, e_last);
    chk("R9 line_done", line_done, e_done);
    chk("R6 dec_valid", dec_valid, d_valid);
    chk("R6 dec_data", dec_data, d_data);
    if (rt) chk("R7 round trip", dec_data, rt_word);
    if (e_valid)
      for (int s = 0; s < 4; s++)
        chk("R7 segment ones bound", 64'($countones(enc_data[s*16 +: 16]) <= 8), 64'd1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; tx_valid = 0; tx_data = 0; rx_valid = 0; rx_data = 0; rx_flag_n = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 enc_valid", enc_valid, 0);
    chk("R1 enc_data", enc_data, 0);
    chk("R1 enc_flag_n", enc_flag_n, 4'hF);
    chk("R1 line_done", line_done, 0);
    chk("R1 dec_valid", dec_valid, 0);
    chk("R1 dec_data", dec_data, 0);
    @(negedge clk); rst_n = 1;
    cycle(0, 64'h0, 0, 0, 64'h0, 4'hF);
    chk("R1 enc_first", enc_first, 0);
    chk("R1 enc_last", enc_last, 0);
    // directed boundaries: 8 ones kept (R4), 9 ones inverted (R3), per-quarter mapping (R2)
    cycle(1, 64'h0000_0000_0000_0000, 0, 1, 64'hFFFF_0000_FFFF_0000, 4'b1010);
    cycle(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 64'h0, 4'h0);
    cycle(1, 64'h00FF_00FF_00FF_00FF, 1, 0, 64'h0, 4'h0);
    cycle(1, 64'h01FF_01FF_01FF_01FF, 1, 0, 64'h0, 4'h0);
    cycle(0, 64'h1234_5678_9ABC_DEF0, 1, 0, 64'h0, 4'h0);
    cycle(1, 64'h0000_0000_0000_01FF, 1, 0, 64'h0, 4'h0);
    cycle(1, 64'h01FF_0000_0000_0000, 1, 0, 64'h0, 4'h0);
    cycle(1, 64'h0000_01FF_00FF_0000, 1, 0, 64'h0, 4'h0);
    cycle(1, 64'hFF00_0000_0000_FFFF, 1, 0, 64'h0, 4'h0);
    cycle(0, 64'h0, 1, 0, 64'h0, 4'h0);
    for (int i = 0; i < 16; i++) cycle(1, rnd_word(), 1, 0, 64'h0, 4'h0);
    for (int i = 0; i < 3000; i++) begin
      logic lp;
      lp = ($urandom % 2) == 0;
      cycle(($urandom % 4) != 0, rnd_word(), lp, $urandom % 2, {$urandom, $urandom}, 4'($urandom));
    end
    cycle(0, 64'h0, 1, 0, 64'h0, 4'h0);
    cycle(0, 64'h0, 0, 0, 64'h0, 4'h0);
    finish_run();
  end
endmodule